// File: doc/BRIEF.md
# Shared Multiply and Shift Execution Unit

This block is an integer execution unit that handles both 32-bit multiplication and every barrel shift on a single multiplier array, so no separate shifter is built. A left shift multiplies the operand by a power of two and keeps the low word of the product. A logical right shift multiplies by the complementary power of two and keeps the high word. An arithmetic right shift does the same with the operand treated as signed, which fills the vacated top bits with copies of the sign. Both product halves are reachable through their own opcodes. Every result leaves on one 32-bit result port as an ordinary register-file write, so there are no dedicated high/low product registers.

The unit is unpipelined and takes several cycles per operation. The build-time parameter `LATENCY` is 2 or 3. With a latency of three, the 32x32 array is split into two half-width partial products that are summed in a second step, which shortens the critical path. While an operation is in flight, `busy` is high so that the surrounding pipeline stalls, and any issue request made during that time is dropped. Division is not handled.

Opcode encoding on `issue_op`: 0 = low product word, 1 = high word signed x signed, 2 = high word unsigned x unsigned, 3 = left logical shift, 4 = right logical shift, 5 = right arithmetic shift, 6 and 7 = unassigned. For shifts, the operand is `issue_a` and the amount is `issue_shamt` (0 to 31). `issue_b` is ignored for shifts.

Top module: `mulshift_unit`

## Requirements
- R1: During and straight after reset, `busy` is 0, `res_valid` is 0 and `res_data` is 0.
- R2: An issue is accepted at a rising edge where `issue_valid` is 1 and `busy` is 0. `busy` is then high for exactly `LATENCY` cycles. An `issue_valid` seen while `busy` is high is ignored: it yields no result and no extra done pulse, and it leaves `res_data` unchanged.
- R3: Count the accepting edge as edge 0. `res_valid` is high for exactly the one cycle that follows edge `LATENCY`, and it is never high together with `busy`. `res_data` changes only together with a done pulse and is held until the next one.
- R4: Opcode 0 returns bits 31:0 of `issue_a * issue_b`.
- R5: Opcode 1 returns bits 63:32 of the product with both operands taken as two's-complement signed.
- R6: Opcode 2 returns bits 63:32 of the product with both operands taken as unsigned.
- R7: Opcode 3 returns `issue_a` shifted left by `issue_shamt`, with zeros entering from the right.
- R8: Opcode 4 returns `issue_a` shifted right by `issue_shamt`, with zeros entering from the left.
- R9: Opcode 5 returns `issue_a` shifted right by `issue_shamt`, with copies of bit 31 entering from the left.
- R10: For opcodes 3, 4 and 5 with a shift amount of 0, the result equals `issue_a` unchanged.
- R11: Opcodes 6 and 7 return 0, with the same busy and done timing as any other operation.
- R12: Results do not depend on the `LATENCY` setting; 2 and 3 give identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Request to start an operation |
| issue_op | input | 3 | Operation code |
| issue_a | input | 32 | First multiplicand, or the value to be shifted |
| issue_b | input | 32 | Second multiplicand; ignored by shifts |
| issue_shamt | input | 5 | Shift amount for opcodes 3 to 5 |
| busy | output | 1 | High while an operation is in flight; stalls the issuing pipeline |
| res_valid | output | 1 | One-cycle done pulse |
| res_data | output | 32 | Result word, held until the next done pulse |

## Verification
The bench drives two instances, one at each latency, with the same operations. This separates the single-array product path from the split partial-product path (R12) and checks the done timing for both. The multiply patterns use small values, all-ones operands and most-negative times most-negative. These distinguish the low word from the signed and unsigned high words and show whether the sign correction is applied to one operand or to both. The shift patterns use amounts 1, 4, 8 and 31 on negative and positive values, which shows whether the power-of-two multiplier and the choice of product half are correct at the edges. Amount 0 exercises the bypass path. Unassigned codes, an issue made while busy and a long run of pseudo-random operands complete the set.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

  localparam int WORD_W  = 32;
  localparam int SHAMT_W = $clog2(WORD_W);
  localparam int OP_W    = 3;

  localparam logic [OP_W-1:0] OP_MUL_LO  = 3'd0;
  localparam logic [OP_W-1:0] OP_MUL_HSS = 3'd1;
  localparam logic [OP_W-1:0] OP_MUL_HUU = 3'd2;
  localparam logic [OP_W-1:0] OP_SHL     = 3'd3;
  localparam logic [OP_W-1:0] OP_SHR_L   = 3'd4;
  localparam logic [OP_W-1:0] OP_SHR_A   = 3'd5;

  // Operation as seen by the array: two factors plus how to read the product
  typedef struct packed {
    logic [WORD_W-1:0] mcand;
    logic [WORD_W-1:0] mplier;
    logic              a_sgn;
    logic              b_sgn;
    logic              bypass;
    logic              take_hi;
    logic              zero_out;
  } ms_prep_t;

  function automatic logic [WORD_W-1:0] pow2(input logic [SHAMT_W:0] e);
    logic [WORD_W-1:0] one;
    one = {{(WORD_W-1){1'b0}}, 1'b1};
    return (int'(e) < WORD_W) ? (one << e) : '0;
  endfunction

  function automatic ms_prep_t prep_ops(input logic [OP_W-1:0]    op,
                                        input logic [WORD_W-1:0]  a,
                                        input logic [WORD_W-1:0]  b,
                                        input logic [SHAMT_W-1:0] sh);
    ms_prep_t p;
    logic [SHAMT_W:0] rexp;
    rexp     = (SHAMT_W+1)'(WORD_W) - {1'b0, sh};
    p        = '0;
    p.mcand  = a;
    p.mplier = b;
    case (op)
      OP_MUL_LO: ;
      OP_MUL_HSS: begin
        p.a_sgn   = 1'b1;
        p.b_sgn   = 1'b1;
        p.take_hi = 1'b1;
      end
      OP_MUL_HUU: p.take_hi = 1'b1;
      OP_SHL: begin
        p.mplier = pow2({1'b0, sh});
        p.bypass = (sh == '0);
      end
      OP_SHR_L: begin
        p.mplier  = pow2(rexp);
        p.take_hi = 1'b1;
        p.bypass  = (sh == '0);
      end
      OP_SHR_A: begin
        p.mplier  = pow2(rexp);
        p.take_hi = 1'b1;
        p.a_sgn   = 1'b1;
        p.bypass  = (sh == '0);
      end
      default: p.zero_out = 1'b1;
    endcase
    return p;
  endfunction

  // Convert an unsigned high word into the signed-operand high word
  function automatic logic [WORD_W-1:0] fix_hi(input logic [WORD_W-1:0] hi_u,
                                               input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic              a_sgn,
                                               input logic              b_sgn);
    logic [WORD_W-1:0] ca, cb;
    ca = (a_sgn && a[WORD_W-1]) ? b : '0;
    cb = (b_sgn && b[WORD_W-1]) ? a : '0;
    return hi_u - ca - cb;
  endfunction

  function automatic logic [WORD_W-1:0] pick_result(input ms_prep_t            p,
                                                    input logic [2*WORD_W-1:0] prod);
    if (p.zero_out)     return '0;
    else if (p.bypass)  return p.mcand;
    else if (p.take_hi) return fix_hi(prod[2*WORD_W-1:WORD_W], p.mcand, p.mplier,
                                      p.a_sgn, p.b_sgn);
    else                return prod[WORD_W-1:0];
  endfunction

endpackage

// File: rtl/ms_ctrl.sv
module ms_ctrl #(
  parameter int LATENCY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  output logic               accept,
  output logic               busy,
  output logic [LATENCY-1:0] phase
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign accept = issue_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (accept)                      cnt_q <= CNT_W'(1);
    else if (cnt_q == CNT_W'(LATENCY))    cnt_q <= '0;
    else if (busy)                        cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar i = 0; i < LATENCY; i++) begin : g_phase
    assign phase[i] = (cnt_q == CNT_W'(i + 1));
  end
endmodule

// File: rtl/ms_mult_array.sv
module ms_mult_array #(
  parameter int W      = 32,
  parameter int NSTAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAGE-1:0] stage_en,
  input  logic [W-1:0]      mcand,
  input  logic [W-1:0]      mplier,
  output logic [2*W-1:0]    prod
);
  localparam int HALF = W / 2;
  localparam int PP_W = W + HALF;

  logic [2*W-1:0] prod_q;
  assign prod = prod_q;

  if (NSTAGE == 1) begin : g_single
    logic [2*W-1:0] full_w;
    assign full_w = (2*W)'(mcand) * (2*W)'(mplier);
    always_ff @(posedge clk) begin
      if (!rst_n)          prod_q <= '0;
      else if (stage_en[0]) prod_q <= full_w;
    end
  end else begin : g_split
    logic [PP_W-1:0] pp_lo_q, pp_hi_q;
    logic [PP_W-1:0] pp_lo_w, pp_hi_w;
    assign pp_lo_w = PP_W'(mcand) * PP_W'(mplier[HALF-1:0]);
    assign pp_hi_w = PP_W'(mcand) * PP_W'(mplier[W-1:HALF]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pp_lo_q <= '0;
        pp_hi_q <= '0;
        prod_q  <= '0;
      end else begin
        if (stage_en[0]) begin
          pp_lo_q <= pp_lo_w;
          pp_hi_q <= pp_hi_w;
        end
        if (stage_en[1])
          prod_q <= {{HALF{1'b0}}, pp_lo_q} + {pp_hi_q, {HALF{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/mulshift_unit.sv
module mulshift_unit #(
  parameter int LATENCY = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               issue_valid,
  input  logic [mulshift_pkg::OP_W-1:0]      issue_op,
  input  logic [mulshift_pkg::WORD_W-1:0]    issue_a,
  input  logic [mulshift_pkg::WORD_W-1:0]    issue_b,
  input  logic [mulshift_pkg::SHAMT_W-1:0]   issue_shamt,
  output logic                               busy,
  output logic                               res_valid,
  output logic [mulshift_pkg::WORD_W-1:0]    res_data
);
  import mulshift_pkg::*;

  localparam int W      = WORD_W;
  localparam int NSTAGE = LATENCY - 1;

  logic               accept_w;
  logic               finish_w;
  logic [LATENCY-1:0] phase_w;
  ms_prep_t           prep_d, prep_q;
  logic [2*W-1:0]     prod_w;
  logic [W-1:0]       res_q;
  logic               done_q;

  assign prep_d = prep_ops(issue_op, issue_a, issue_b, issue_shamt);

  ms_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .accept      (accept_w),
    .busy        (busy),
    .phase       (phase_w)
  );

  assign finish_w = phase_w[LATENCY-1];

  always_ff @(posedge clk) begin
    if (!rst_n)        prep_q <= '0;
    else if (accept_w) prep_q <= prep_d;
  end

  ms_mult_array #(.W(W), .NSTAGE(NSTAGE)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_en (phase_w[NSTAGE-1:0]),
    .mcand    (prep_q.mcand),
    .mplier   (prep_q.mplier),
    .prod     (prod_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_w;
      if (finish_w) res_q <= pick_result(prep_q, prod_w);
    end
  end

  assign res_valid = done_q;
  assign res_data  = res_q;
endmodule

// File: rtl/ms_checker.sv
module ms_checker #(
  parameter int LATENCY = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [2:0]  issue_op,
  input logic [31:0] issue_a,
  input logic [4:0]  issue_shamt,
  input logic        accept_w,
  input logic        busy,
  input logic        res_valid,
  input logic [31:0] res_data
);
  logic [2:0]  since_q;
  logic [2:0]  st_op;
  logic [31:0] st_a;
  logic [4:0]  st_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      st_op   <= '0;
      st_a    <= '0;
      st_sh   <= '0;
    end else if (issue_valid && !busy) begin
      since_q <= 3'd1;
      st_op   <= issue_op;
      st_a    <= issue_a;
      st_sh   <= issue_shamt;
    end else if (since_q != 3'd0 && since_q != 3'd7) begin
      since_q <= since_q + 3'd1;
    end
  end

  p_busy_from_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept_w));

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && res_valid));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_done_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (since_q == 3'(LATENCY + 1)));

  p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_data) |-> res_valid);

  p_zero_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && st_op >= 3'd3 && st_op <= 3'd5 && st_sh == 5'd0) |-> (res_data == st_a));

  p_unassigned_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && st_op >= 3'd6) |-> (res_data == 32'd0));
endmodule

bind mulshift_unit ms_checker #(.LATENCY(LATENCY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_op    (issue_op),
  .issue_a     (issue_a),
  .issue_shamt (issue_shamt),
  .accept_w    (accept_w),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_data    (res_data)
);

// File: tb/mulshift_unit_tb_top.sv
`timescale 1ns/1ps
module mulshift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_op = '0;
  logic [31:0] issue_a = '0;
  logic [31:0] issue_b = '0;
  logic [4:0]  issue_shamt = '0;
  logic        busy2, busy3, rv2, rv3;
  logic [31:0] rd2, rd3;

  int nchecks = 0;
  int nfail   = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  logic [31:0] q2_data[$], q3_data[$];
  int          q2_cyc[$],  q3_cyc[$];
  string       q2_tag[$],  q3_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mulshift_unit #(.LATENCY(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b), .issue_shamt(issue_shamt),
    .busy(busy2), .res_valid(rv2), .res_data(rd2));

  mulshift_unit #(.LATENCY(3)) dut_l3_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b), .issue_shamt(issue_shamt),
    .busy(busy3), .res_valid(rv3), .res_data(rd3));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    longint          sp;
    logic [63:0]     up;
    case (op)
      3'd0: begin up = {32'd0, a} * {32'd0, b}; return up[31:0]; end
      3'd1: begin sp = longint'($signed(a)) * longint'($signed(b)); return sp[63:32]; end
      3'd2: begin up = {32'd0, a} * {32'd0, b}; return up[63:32]; end
      3'd3: return a << sh;
      3'd4: return a >> sh;
      3'd5: return $signed(a) >>> sh;
      default: return 32'd0;
    endcase
  endfunction

  // Scoreboard monitors: one per latency variant
  always @(negedge clk) begin
    if (rst_n && rv2) begin
      if (q2_data.size() == 0) chk(1'b0, "R3 unexpected done pulse L2", rd2, 32'd0);
      else begin
        logic [31:0] e; int ec; string t;
        e = q2_data.pop_front(); ec = q2_cyc.pop_front(); t = q2_tag.pop_front();
        chk(rd2 === e, {t, " L2 data"}, rd2, e);
        chk(cyc == ec, "R3 done timing L2", cyc, ec);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rv3) begin
      if (q3_data.size() == 0) chk(1'b0, "R3 unexpected done pulse L3", rd3, 32'd0);
      else begin
        logic [31:0] e; int ec; string t;
        e = q3_data.pop_front(); ec = q3_cyc.pop_front(); t = q3_tag.pop_front();
        chk(rd3 === e, {t, " L3 data (R12)"}, rd3, e);
        chk(cyc == ec, "R3 done timing L3", cyc, ec);
      end
    end
  end

  // Driver: drives one operation; optionally presents an intruding request while busy
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input string tag, input bit intrude);
    logic [31:0] e;
    @(negedge clk);
    while (busy2 || busy3) @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_a = a; issue_b = b; issue_shamt = sh;
    e = model(op, a, b, sh);
    q2_data.push_back(e); q2_cyc.push_back(cyc + 1 + 2); q2_tag.push_back(tag);
    q3_data.push_back(e); q3_cyc.push_back(cyc + 1 + 3); q3_tag.push_back(tag);
    @(negedge clk);
    chk(busy2 && busy3, "R2 busy after accept", {30'd0, busy3, busy2}, 32'd3);
    if (intrude) begin
      issue_op = 3'd0; issue_a = 32'h1234_5678; issue_b = 32'h9; issue_shamt = 5'd3;
      @(negedge clk);
    end
    issue_valid = 1'b0;
  endtask

  task automatic drain();
    while (q2_data.size() != 0 || q3_data.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy2 && !busy3, "R1 busy in reset", {30'd0, busy3, busy2}, 32'd0);
    chk(!rv2 && !rv3, "R1 done in reset", {30'd0, rv3, rv2}, 32'd0);
    chk(rd2 == 0 && rd3 == 0, "R1 result in reset", rd2 | rd3, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy2 && !rv2 && rd2 == 0, "R1 idle after reset", {31'd0, busy2 | rv2}, 32'd0);

    issue(3'd0, 32'd7, 32'd6, 5'd0, "R4 mul lo small", 1'b0);
    issue(3'd0, 32'hFFFF_FFFF, 32'd2, 5'd0, "R4 mul lo wrap", 1'b0);
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R5 mulh -1*-1", 1'b0);
    issue(3'd1, 32'h8000_0000, 32'h8000_0000, 5'd0, "R5 mulh minneg", 1'b0);
    issue(3'd1, 32'hFFFF_FFFE, 32'd3, 5'd0, "R5 mulh mixed sign", 1'b0);
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R6 mulhu ones", 1'b0);
    issue(3'd2, 32'h8000_0000, 32'd4, 5'd0, "R6 mulhu top bit", 1'b0);
    issue(3'd3, 32'd1, 32'hDEAD_BEEF, 5'd31, "R7 shl by 31", 1'b0);
    issue(3'd3, 32'hF0F0_F0F0, 32'd0, 5'd4, "R7 shl by 4", 1'b0);
    issue(3'd4, 32'h8000_0000, 32'd0, 5'd31, "R8 shr logical 31", 1'b0);
    issue(3'd4, 32'hFFFF_FFFF, 32'd0, 5'd1, "R8 shr logical 1", 1'b0);
    issue(3'd5, 32'h8000_0000, 32'd0, 5'd4, "R9 shr arith neg 4", 1'b0);
    issue(3'd5, 32'h7FFF_0000, 32'd0, 5'd8, "R9 shr arith pos 8", 1'b0);
    issue(3'd5, 32'h8000_0001, 32'd0, 5'd31, "R9 shr arith neg 31", 1'b0);
    issue(3'd5, 32'hC000_0000, 32'd0, 5'd1, "R9 shr arith neg 1", 1'b0);
    issue(3'd3, 32'hA5A5_0001, 32'd0, 5'd0, "R10 shl zero", 1'b0);
    issue(3'd4, 32'h8765_4321, 32'd0, 5'd0, "R10 shr logical zero", 1'b0);
    issue(3'd5, 32'h8765_4321, 32'd0, 5'd0, "R10 shr arith zero", 1'b0);
    issue(3'd6, 32'h1111_1111, 32'h2222_2222, 5'd5, "R11 code 6", 1'b0);
    issue(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd9, "R11 code 7", 1'b0);
    drain();

    // R2: request while busy is dropped; result stays the first operation's
    issue(3'd2, 32'd1000, 32'd3000, 5'd0, "R2 op before intrusion", 1'b0);
    drain();
    issue(3'd0, 32'd11, 32'd13, 5'd0, "R2 first op with intrusion", 1'b1);
    drain();
    chk(rd2 == 32'd143, "R2 intruding request ignored L2", rd2, 32'd143);
    chk(rd3 == 32'd143, "R2 intruding request ignored L3", rd3, 32'd143);
    repeat (6) @(negedge clk);
    chk(rd2 == 32'd143 && rd3 == 32'd143, "R3 result held", rd2, 32'd143);

    // Pseudo-random mix across all codes (R4..R12)
    begin
      logic [31:0] rs = 32'h1ACE_B00C;
      logic [31:0] ra, rb;
      for (int i = 0; i < 160; i++) begin
        rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5); ra = rs;
        rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5); rb = rs;
        issue(3'(i % 8), ra, rb, rb[4:0], "R12 random mix", 1'b0);
      end
    end
    drain();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule